// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a target-only SMBus endpoint that gives a bus controller access to a small bank of byte-wide configuration registers. It oversamples the SCL and SDA lines with the system clock and cleans each line with a synchronizer and a majority filter. It recognises start, repeated-start and stop conditions and answers only to its own 7-bit address. It acknowledges and returns read data by pulling SDA low through an open-drain enable. It never drives the line high.

A write carries an offset byte, then a byte count, then that many data bytes. Each data byte lands at the current offset, and the offset then steps forward by one. A read first sets the offset with a short write phase. After a repeated start with the read address, the block sends a count byte equal to the number of registers from that offset up to the last one. It then sends register contents until the controller answers a byte with a not-acknowledge. The register contents are also presented in parallel to the surrounding logic.

Top module: `smbr_regslave`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers take their defaults and SDA is released. By offset 0..6 the defaults are 21h, 54h, 00h, 86h, 00h, 00h and 83h.
- R2: The block acknowledges an address byte only when its upper seven bits equal 1101001 (D2h write, D3h read). For any other address it leaves SDA released and changes no register.
- R3: In a write, the address, offset and count bytes are acknowledged, and every data byte up to the count is acknowledged and stored at offset, offset+1, and so on.
- R4: A write count of 00h is not acknowledged and leaves every register unchanged.
- R5: After a write phase setting offset K, a repeated start and D3h, the first byte returned is 7-K when K < 7, else 00h. It is followed by the registers from offset K upward.
- R6: A not-acknowledge from the controller on a returned byte ends the read. SDA stays released until the next start.
- R7: The offset advances after every data byte. Reads past offset 6 return 00h, and writes past offset 6 are discarded.
- R8: Only writable bits take written data. The writable masks for offsets 0..6 are FFh, FFh, E0h, FEh, 00h, 00h and 00h, and every other bit keeps its default.
- R9: A data byte sent after the write count is exhausted is not acknowledged and changes no register.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset, returns registers to defaults |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High to pull SDA low; low releases the line |
| cfg_regs | output | NUM_REGS*8 | Register contents, offset i at bits [8i+7:8i] |

## Verification
A wrong framing state shows up at the ports within one bit time. Either the acknowledge bit of the same byte is wrong, or SDA moves while SCL is high. A wrong pointer or count shows up on the next read-back, as a wrong count byte or shifted data. A wrong write shows on `cfg_regs` one system clock after the acknowledge of the byte concerned. Random offsets and counts that cross the end of the bank are compared against a shadow model after every transaction, so a corrupted register is seen at the latest at the end of the next transfer.

// File: rtl/smbr_pkg.sv
// Shared definitions for the SMBus register target: states, byte phases
// and the per-register default values and writable masks.
package smbr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a start condition
        S_RX,     // shifting in a byte from the controller
        S_RXACK,  // our acknowledge slot after a received byte
        S_TX,     // shifting out a byte to the controller
        S_TXACK   // controller acknowledge slot after a sent byte
    } link_state_e;

    typedef enum logic [2:0] {
        P_ADDR,   // next received byte is the address
        P_OFFSET, // next received byte is the register offset
        P_COUNT,  // next received byte is the write count
        P_WDATA,  // next received bytes are write data
        P_RCOUNT  // read addressed: count byte goes out next
    } byte_phase_e;

    // Power-up value of register idx.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h21;
            1:       return 8'h54;
            3:       return 8'h86;
            6:       return 8'h83;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of register idx that a bus write may change.
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0, 1:    return 8'hFF;
            2:       return 8'hE0;
            3:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbr_line_filter.sv
// Cleans one open-drain bus line: two-flop synchronizer followed by a
// TAPS-sample majority vote. Assumes the line is idle-high, so reset
// presets every stage to one. Latency from pin to output is TAPS+2 clocks
// in the worst case.
module smbr_line_filter #(
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [1:0]      sync_q;
    logic [TAPS-1:0] hist_q;
    logic            vote_q;

    // Synchronize, keep a short history and take the majority of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            vote_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[TAPS-2:0], sync_q[1]};
            vote_q <= ($countones(hist_q) > (TAPS / 2));
        end
    end

    assign line_o = vote_q;

endmodule

// File: rtl/smbr_bus_cond.sv
// Detects SCL edges and start/stop conditions from the filtered lines.
// Assumes both inputs are already synchronous and glitch-free.
module smbr_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);

    logic scl_prev_q, sda_prev_q;

    // Remember the previous filtered level of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    // Edge and condition decode: SDA moving while SCL stays high.
    always_comb begin
        scl_rise   = scl_f & ~scl_prev_q;
        scl_fall   = ~scl_f & scl_prev_q;
        cond_start = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
        cond_stop  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    end

endmodule

// File: rtl/smbr_reg_bank.sv
// Byte-wide register bank with per-bit write masks and reset defaults.
// Writes outside 0..NUM_REGS-1 are dropped, reads there return zero.
module smbr_reg_bank #(
    parameter int NUM_REGS = 7,
    parameter int AW       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    import smbr_pkg::*;

    localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [AW-1:0] LIMIT = AW'(NUM_REGS);

    logic [7:0] mem_q [NUM_REGS];

    // Load defaults on reset, otherwise merge writable bits of a write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)
                mem_q[i] <= reg_default(i);
            else if (wr_en && wr_addr == AW'(i))
                mem_q[i] <= (wr_data & reg_wmask(i)) | (mem_q[i] & ~reg_wmask(i));
        end
    end

    // Read mux, zero past the last register.
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr < LIMIT)
            rd_data = mem_q[rd_addr[IDXW-1:0]];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        localparam logic [7:0] WM  = reg_wmask(g);
        localparam logic [7:0] DEF = reg_default(g);
        assign regs_o[8*g +: 8] = mem_q[g];

        AST_RO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_q[g] & ~WM) == (DEF & ~WM)); // R8
        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(g)) |=> ((mem_q[g] & WM) == ($past(wr_data) & WM))); // R3
    end

endmodule

// File: rtl/smbr_regslave.sv
// SMBus target giving indexed block read/write access to a register bank.
// Assumes clk runs at least ~20x the SCL rate so filtering delay fits in
// the SCL low time; no clock stretching, no packet error code.
module smbr_regslave #(
    parameter logic [6:0] SLAVE_ADDR = 7'b1101001,
    parameter int         NUM_REGS   = 7,
    parameter int         FILT_TAPS  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    import smbr_pkg::*;

    localparam int PTR_W = 8;
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);

    logic [1:0] raw_lines, flt_lines;
    logic       scl_f, sda_f, scl_rise, scl_fall, cond_start, cond_stop;

    link_state_e      state_q;
    byte_phase_e      phase_q, phase_nxt;
    logic [3:0]       bitcnt_q;
    logic [7:0]       sh_q, tx_q, remain_q;
    logic [PTR_W-1:0] ptr_q;
    logic             sda_oe_q, mack_q, ack_now, byte_done;
    logic             wr_en;
    logic [7:0]       rd_data, rd_count;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        smbr_line_filter #(.TAPS(FILT_TAPS)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    assign scl_f = flt_lines[0];
    assign sda_f = flt_lines[1];

    smbr_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (scl_f),
        .sda_f      (sda_f),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .cond_start (cond_start),
        .cond_stop  (cond_stop)
    );

    smbr_reg_bank #(.NUM_REGS(NUM_REGS), .AW(PTR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr_q),
        .wr_data (sh_q),
        .rd_addr (ptr_q),
        .rd_data (rd_data),
        .regs_o  (cfg_regs)
    );

    // Count byte of a read: registers left from the current offset.
    assign rd_count = (ptr_q < LIMIT) ? (LIMIT - ptr_q) : 8'h00;

    // A received byte is complete at the SCL fall after its eighth bit.
    assign byte_done = (state_q == S_RX) && scl_fall && (bitcnt_q == 4'd8);
    assign wr_en     = byte_done && (phase_q == P_WDATA) && (remain_q != 8'h00);

    // Acknowledge decision and next byte phase for a completed byte.
    always_comb begin
        ack_now   = 1'b0;
        phase_nxt = phase_q;
        unique case (phase_q)
            P_ADDR: if (sh_q[7:1] == SLAVE_ADDR) begin
                ack_now   = 1'b1;
                phase_nxt = sh_q[0] ? P_RCOUNT : P_OFFSET;
            end
            P_OFFSET: begin ack_now = 1'b1; phase_nxt = P_COUNT; end
            P_COUNT:  begin ack_now = (sh_q != 8'h00); phase_nxt = P_WDATA; end
            P_WDATA:  ack_now = (remain_q != 8'h00);
            default:  ack_now = 1'b0;
        endcase
    end

    // Bit-level transaction sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            phase_q  <= P_ADDR;
            bitcnt_q <= '0;
            sh_q     <= '0;
            tx_q     <= '0;
            remain_q <= '0;
            ptr_q    <= '0;
            sda_oe_q <= 1'b0;
            mack_q   <= 1'b0;
        end else if (cond_start) begin
            state_q  <= S_RX;
            phase_q  <= P_ADDR;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else if (cond_stop) begin
            state_q  <= S_IDLE;
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_RX: begin
                    if (scl_rise) begin
                        sh_q     <= {sh_q[6:0], sda_f};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (byte_done) begin
                        state_q  <= ack_now ? S_RXACK : S_IDLE;
                        sda_oe_q <= ack_now;
                        phase_q  <= phase_nxt;
                        if (phase_q == P_OFFSET) ptr_q <= sh_q;
                        if (phase_q == P_COUNT)  remain_q <= sh_q;
                        if (wr_en) begin
                            remain_q <= remain_q - 8'd1;
                            if (ptr_q != '1) ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
                S_RXACK: if (scl_fall) begin
                    bitcnt_q <= '0;
                    if (phase_q == P_RCOUNT) begin
                        state_q  <= S_TX;
                        sda_oe_q <= ~rd_count[7];
                        tx_q     <= {rd_count[6:0], 1'b0};
                    end else begin
                        state_q  <= S_RX;
                        sda_oe_q <= 1'b0;
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt_q == 4'd8) begin
                            sda_oe_q <= 1'b0;
                            state_q  <= S_TXACK;
                        end else begin
                            sda_oe_q <= ~tx_q[7];
                            tx_q     <= {tx_q[6:0], 1'b0};
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_q  <= S_TX;
                            bitcnt_q <= '0;
                            sda_oe_q <= ~rd_data[7];
                            tx_q     <= {rd_data[6:0], 1'b0};
                            if (ptr_q != '1) ptr_q <= ptr_q + 1'b1;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> $past(!scl_f || cond_start || cond_stop)); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !sda_oe_q); // R6
    AST_ZERO_COUNT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == P_COUNT && sh_q == 8'h00) |=> (!sda_oe_q && state_q == S_IDLE)); // R4
    AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q == S_RXACK && sda_oe_q)); // R3

endmodule

// File: tb/smbr_regslave_tb.sv
// Bench: bit-banged bus controller, shadow register model, random and
// directed transactions.
module smbr_regslave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int NREG       = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_oe;
    logic            sda_line;
    logic [NREG*8-1:0] cfg;

    int checks = 0;
    int fails  = 0;
    int sda_viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [16];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbr_regslave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg)
    );

    function automatic logic [7:0] def_of(input int i);
        logic [7:0] t [NREG] = '{8'h21, 8'h54, 8'h00, 8'h86, 8'h00, 8'h00, 8'h83};
        return t[i];
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        logic [7:0] t [NREG] = '{8'hFF, 8'hFF, 8'hE0, 8'hFE, 8'h00, 8'h00, 8'h00};
        return t[i];
    endfunction

    function automatic logic [7:0] exp_read(input int i);
        return (i < NREG) ? model[i] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) model[i] = def_of(i);
    endtask

    task automatic check_cfg(input string req);
        for (int i = 0; i < NREG; i++)
            check(cfg[8*i +: 8] == model[i], req, cfg[8*i +: 8], model[i]);
    endtask

    // SDA drive must only move while SCL is low (R10).
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) sda_viol++;
        prev_oe <= sda_oe;
    end

    task automatic bus_start();
        sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int k = 7; k >= 0; k--) begin
            tick(Q); sda_m = b[k]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
        end
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            b[k] = sda_line;
            tick(Q); scl_m = 1'b0;
        end
        tick(Q); sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    endtask

    // Write: offset, count, nsend bytes from wbuf; acks and model checked.
    task automatic write_block(input int off, input int cnt, input int nsend, input string req);
        bit a;
        bus_start();
        send_byte(8'hD2, a); check(a, {req, " addr ack"}, a, 1);
        send_byte(off[7:0], a); check(a, {req, " offset ack"}, a, 1);
        send_byte(cnt[7:0], a); check(a == (cnt != 0), {req, " count ack"}, a, cnt != 0);
        if (cnt != 0) begin
            for (int k = 0; k < nsend; k++) begin
                send_byte(wbuf[k], a);
                check(a == (k < cnt), {req, " data ack"}, a, k < cnt);
                if (k < cnt && off + k < NREG)
                    model[off+k] = (wbuf[k] & mask_of(off+k)) | (model[off+k] & ~mask_of(off+k));
                if (!a) break;
            end
        end
        bus_stop();
        check_cfg(req);
    endtask

    // Read: set offset, repeated start, count byte then n data bytes.
    task automatic read_block(input int off, input int n, input string req);
        bit a;
        logic [7:0] b;
        int ecount;
        ecount = (off < NREG) ? NREG - off : 0;
        bus_start();
        send_byte(8'hD2, a); check(a, {req, " addr ack"}, a, 1);
        send_byte(off[7:0], a); check(a, {req, " offset ack"}, a, 1);
        bus_rstart();
        send_byte(8'hD3, a); check(a, {req, " read addr ack"}, a, 1);
        recv_byte(n > 0, b); check(b == ecount[7:0], {req, " R5 count"}, b, ecount);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            check(b == exp_read(off + k), {req, " R7 data"}, b, exp_read(off + k));
        end
        tick(2);
        check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit a;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_reset();
        tick(5);
        check(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(10);
        check_cfg("R1 defaults");

        // R2: foreign address is ignored.
        bus_start(); send_byte(8'hA4, a); check(!a, "R2 foreign addr nack", a, 0);
        send_byte(8'h00, a); check(!a, "R2 no ack after foreign", a, 0); bus_stop();
        check_cfg("R2 no change");

        // R3: plain write, then read all back (R5, R7).
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hFF;
        write_block(0, 3, 3, "R3 write");
        read_block(0, 7, "R5 full read");

        // R4: zero count refused.
        write_block(1, 0, 0, "R4 zero count");

        // R8: all-ones / all-zeros across every register.
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'hFF;
        write_block(0, 7, 7, "R8 ones");
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'h00;
        write_block(0, 7, 7, "R8 zeros");

        // R7: write crossing the end of the bank.
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        write_block(5, 4, 4, "R7 past end write");

        // R9: bytes beyond the count are refused.
        wbuf[0] = 8'h77; wbuf[1] = 8'h99; wbuf[2] = 8'h55;
        write_block(1, 1, 3, "R9 excess data");

        // R5/R7 boundary reads.
        read_block(6, 2, "R5 last offset");
        read_block(9, 2, "R7 beyond end");
        read_block(3, 0, "R6 count only");

        // Random mix.
        for (int t = 0; t < 20; t++) begin
            int off, cnt;
            off = $urandom_range(0, 8);
            cnt = $urandom_range(1, 4);
            if ($urandom_range(0, 1) == 1) begin
                for (int k = 0; k < cnt; k++) wbuf[k] = 8'($urandom);
                write_block(off, cnt, cnt, "R3 random write");
            end else begin
                read_block(off, cnt, "R5 random read");
            end
        end

        // R1: reset mid-run restores defaults.
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(10);
        model_reset();
        check_cfg("R1 reset restores");
        read_block(0, 7, "R1 read after reset");

        check(sda_viol == 0, "R10 sda moved while scl high", sda_viol, 0);
        finish_run();
    end

endmodule